// File: doc/BRIEF.md
# Multi-mode graphics byte pixel decoder

This block turns one graphics byte, fetched for a sprite object, into a serial run of pixel slots at the high-resolution pixel rate. Each slot carries a palette number, a colour number from 0 to 3 and a transparent flag. A later stage looks these up in palette RAM and writes them into the line buffer. The byte arrives with a 3-bit palette number, a 2-bit read-mode field, a write-mode bit taken from the object header and a kangaroo control bit. Together these select one of six bit interpretations and the transparency policy.

Low-resolution formats repeat each pixel on two consecutive slots. A byte therefore always fills either 8 or 4 output slots. Some high-resolution formats borrow data bits as palette bits, or palette bits as colour bits. A zero pixel is made transparent or shown as background according to its partner inside a high-resolution pair and to the kangaroo control. The block requests the next byte with a ready/valid handshake. It accepts a new byte only when no slot of the previous byte is still pending, so a steady supply of bytes streams out without gaps.

Top module: `gpix_decoder`

## Requirements
- R1: The format is picked from the read mode and the write mode. Read mode 2 gives hi-res 2-bit pairs (write 1) or hi-res palette-colour (write 0). Read mode 3 gives hi-res palette-borrow (write 1) or hi-res mono (write 0). Read mode 0 gives lo-res 4-colour (write 1) or lo-res 2-bit (write 0). The unused read mode 1 behaves exactly like read mode 0.
- R2: Lo-res 2-bit: slots 2p and 2p+1 carry pixel p. Pixel p takes colour bits [7-2p:6-2p]. The palette is the input palette.
- R3: Lo-res 4-colour: pixel 0 (slots 0,1) has index {b3,b2,b7,b6} and pixel 1 (slots 2,3) has index {b1,b0,b5,b4}. The palette is {P2, index[3:2]} and the colour is index[1:0].
- R4: Hi-res mono: slot k has colour 2 when bit 7-k is set and colour 0 when it is clear. The palette is the input palette.
- R5: Hi-res 2-bit pairs: slot k (k=0..3) has colour {b[7-k], b[3-k]} and palette {P2,0,0}.
- R6: Hi-res palette-borrow: slot k (k=0..3) has colour 2 when b[7-k] is set, else 0. Slots 0 and 1 use palette {P2,b3,b2} and slots 2 and 3 use {P2,b1,b0}.
- R7: Hi-res palette-colour: slot k (k=0..7) has colour {b[7-k], P1} for even k and {b[7-k], P0} for odd k. The palette is {P2,0,0}.
- R8: With kangaroo off, a slot with colour 0 is transparent only when the other slot of its pair (slots 2j and 2j+1) also has colour 0. Otherwise it is output as background.
- R9: With kangaroo on, no slot is ever transparent; colour-0 slots are output as background.
- R10: Formats selected with write mode 1 emit 4 slots and the others emit 8. Slot 0 is valid in the cycle after the accepting edge and the rest follow on consecutive cycles. in_ready is high only while no slot of the current byte remains to be output, so inputs presented while busy are ignored.
- R11: During and right after reset, out_valid is low and in_ready is high.
- R12: Background is signalled as colour 0 with transparent low. A transparent slot also carries colour 0. Every slot carries the palette its format decodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A graphics byte is offered |
| in_ready | output | 1 | Block takes a byte on this edge when in_valid is high |
| in_data | input | 8 | Graphics byte |
| in_pal | input | 3 | Palette number of the object |
| in_rmode | input | 2 | Read-mode field |
| in_wmode | input | 1 | Write-mode bit from the object header |
| in_kanga | input | 1 | Kangaroo control: 1 disables transparency |
| out_valid | output | 1 | A pixel slot is present this cycle |
| out_pal | output | 3 | Palette number of the slot |
| out_color | output | 2 | Colour number of the slot (0 = background or transparent) |
| out_transp | output | 1 | Slot is transparent |

## Verification
Slot 0 of an accepted byte appears in the first cycle after the accepting edge, and slot k appears k cycles later. in_ready rises in the same cycle that the last slot is shown. The bench offers each byte at a falling edge and lets the next rising edge take it. It then samples the outputs at each following falling edge, compares slot k at the k-th one and checks in_ready there. While a byte streams out, the inputs are set to conflicting values so that an early acceptance would corrupt later slots. The sweep covers every byte value in all eight mode combinations, with both kangaroo settings.

// File: rtl/gpix_pkg.sv
package gpix_pkg;
  localparam int PAL_W = 3;
  localparam int COL_W = 2;
  localparam int BYTE_W = 8;
  localparam int MAX_SLOTS = 8;

  typedef enum logic [2:0] {
    FMT_LO2   = 3'd0,
    FMT_LO4   = 3'd1,
    FMT_HI1   = 3'd2,
    FMT_HI2   = 3'd3,
    FMT_HIPAL = 3'd4,
    FMT_HICOL = 3'd5
  } fmt_e;

  typedef struct packed {
    logic [PAL_W-1:0] pal;
    logic [COL_W-1:0] col;
  } raw_t;

  typedef struct packed {
    logic [PAL_W-1:0] pal;
    logic [COL_W-1:0] col;
    logic             transp;
  } pix_t;

  localparam int PIX_W = $bits(pix_t);

  function automatic fmt_e pick_fmt(input logic [1:0] rmode, input logic wmode);
    case (rmode)
      2'b10:   return wmode ? FMT_HI2   : FMT_HICOL;
      2'b11:   return wmode ? FMT_HIPAL : FMT_HI1;
      default: return wmode ? FMT_LO4   : FMT_LO2;
    endcase
  endfunction
endpackage

// File: rtl/gpix_decode.sv
module gpix_decode
  import gpix_pkg::*;
#(
  parameter int SLOTS = MAX_SLOTS
) (
  input  logic [BYTE_W-1:0]    data,
  input  logic [PAL_W-1:0]     pal,
  input  fmt_e                 fmt,
  output raw_t [SLOTS-1:0]     raw
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LP  = (s / 2) % 4;        // lo-res pixel, 2-bit format
    localparam int L4  = (s / 2) % 2;        // lo-res pixel, 4-colour format
    localparam int Q   = s % 4;              // hi-res pixel in 4-slot formats
    localparam int K   = s % 8;              // hi-res pixel in 8-slot formats
    localparam int CB  = (Q < 2) ? 2 : 0;    // borrowed palette bits
    localparam int PB  = (K % 2 == 0) ? 1 : 0;

    logic [3:0] idx4;
    assign idx4 = {data[3-2*L4], data[2-2*L4], data[7-2*L4], data[6-2*L4]};

    always_comb begin
      raw[s] = '0;
      case (fmt)
        FMT_LO2: begin
          raw[s].pal = pal;
          raw[s].col = {data[7-2*LP], data[6-2*LP]};
        end
        FMT_LO4: begin
          raw[s].pal = {pal[2], idx4[3:2]};
          raw[s].col = idx4[1:0];
        end
        FMT_HI1: begin
          raw[s].pal = pal;
          raw[s].col = data[7-K] ? 2'd2 : 2'd0;
        end
        FMT_HI2: begin
          raw[s].pal = {pal[2], 2'b00};
          raw[s].col = {data[7-Q], data[3-Q]};
        end
        FMT_HIPAL: begin
          raw[s].pal = {pal[2], data[CB+1], data[CB]};
          raw[s].col = data[7-Q] ? 2'd2 : 2'd0;
        end
        FMT_HICOL: begin
          raw[s].pal = {pal[2], 2'b00};
          raw[s].col = {data[7-K], pal[PB]};
        end
        default: raw[s] = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpix_transp.sv
module gpix_transp
  import gpix_pkg::*;
#(
  parameter int SLOTS = MAX_SLOTS,
  localparam int PAIRS = SLOTS / 2
) (
  input  raw_t [SLOTS-1:0] raw,
  input  logic             kanga,
  output pix_t [SLOTS-1:0] pix
);
  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic both_zero;
    assign both_zero = (raw[2*j].col == '0) && (raw[2*j+1].col == '0);
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic is_zero;
      assign is_zero = (raw[2*j+h].col == '0);
      always_comb begin
        pix[2*j+h].pal    = raw[2*j+h].pal;
        pix[2*j+h].col    = raw[2*j+h].col;
        pix[2*j+h].transp = is_zero && both_zero && !kanga;
      end
    end
  end
endmodule

// File: rtl/gpix_serial.sv
module gpix_serial #(
  parameter int SLOTS = 8,
  parameter int PW    = 6,
  localparam int CW   = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SLOTS*PW-1:0] load_vec,
  input  logic [CW:0]         load_n,
  output logic                idle,
  output logic                out_valid,
  output logic [PW-1:0]       out_word
);
  logic [SLOTS*PW-1:0] shreg;
  logic [CW:0]         left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_word  <= load_vec[PW-1:0];
      shreg     <= load_vec >> PW;
      left      <= load_n - 1'b1;
      out_valid <= 1'b1;
    end else if (left != '0) begin
      out_word  <= shreg[PW-1:0];
      shreg     <= shreg >> PW;
      left      <= left - 1'b1;
      out_valid <= 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end

  assign idle = (left == '0);
endmodule

// File: rtl/gpix_decoder.sv
module gpix_decoder
  import gpix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [PAL_W-1:0]  in_pal,
  input  logic [1:0]        in_rmode,
  input  logic              in_wmode,
  input  logic              in_kanga,
  output logic              out_valid,
  output logic [PAL_W-1:0]  out_pal,
  output logic [COL_W-1:0]  out_color,
  output logic              out_transp
);
  localparam int SLOTS  = MAX_SLOTS;
  localparam int CW     = $clog2(SLOTS);
  localparam int NARROW = SLOTS / 2;

  fmt_e             fmt;
  raw_t [SLOTS-1:0] raw;
  pix_t [SLOTS-1:0] pix;
  logic [CW:0]      n_slots;
  logic             idle;
  logic             load;
  pix_t             word;

  assign fmt     = pick_fmt(in_rmode, in_wmode);
  assign n_slots = in_wmode ? (CW+1)'(NARROW) : (CW+1)'(SLOTS);
  assign load    = in_valid && idle;

  gpix_decode #(.SLOTS(SLOTS)) u_decode (
    .data (in_data),
    .pal  (in_pal),
    .fmt  (fmt),
    .raw  (raw)
  );

  gpix_transp #(.SLOTS(SLOTS)) u_transp (
    .raw   (raw),
    .kanga (in_kanga),
    .pix   (pix)
  );

  gpix_serial #(.SLOTS(SLOTS), .PW(PIX_W)) u_serial (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_vec  (pix),
    .load_n    (n_slots),
    .idle      (idle),
    .out_valid (out_valid),
    .out_word  (word)
  );

  assign in_ready   = idle;
  assign out_pal    = word.pal;
  assign out_color  = word.col;
  assign out_transp = word.transp;
endmodule

// File: rtl/gpix_decoder_chk.sv
module gpix_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_kanga,
  input logic       out_valid,
  input logic [1:0] out_color,
  input logic       out_transp
);
  logic kanga_q;

  always_ff @(posedge clk) begin
    if (rst)                       kanga_q <= 1'b0;
    else if (in_valid && in_ready) kanga_q <= in_kanga;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R11
  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid); // R10
  AST_BUSY_STREAMS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_ready) |=> out_valid); // R10
  AST_TRANSP_COLOR0: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_transp) |-> (out_color == 2'd0)); // R12
  AST_KANGA_OPAQUE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && kanga_q) |-> !out_transp); // R9
endmodule

bind gpix_decoder gpix_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_kanga   (in_kanga),
  .out_valid  (out_valid),
  .out_color  (out_color),
  .out_transp (out_transp)
);

// File: tb/gpix_decoder_tb.sv
module gpix_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_pal = '0;
  logic [1:0] in_rmode = '0;
  logic       in_wmode = 1'b0;
  logic       in_kanga = 1'b0;
  logic       out_valid;
  logic [2:0] out_pal;
  logic [1:0] out_color;
  logic       out_transp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpix_decoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_pal     (in_pal),
    .in_rmode   (in_rmode),
    .in_wmode   (in_wmode),
    .in_kanga   (in_kanga),
    .out_valid  (out_valid),
    .out_pal    (out_pal),
    .out_color  (out_color),
    .out_transp (out_transp)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Raw colour and palette of slot k, written from the format rules.
  function automatic void ref_raw(input logic [7:0] b, input logic [2:0] p, input logic [1:0] rd,
                                  input logic wr, input int k,
                                  output logic [2:0] rp, output logic [1:0] rc);
    logic [3:0] idx;
    if (rd[1] == 1'b0) begin
      if (!wr) begin
        rc = 2'((b >> (6 - 2*(k/2))) & 8'd3);  // R2
        rp = p;
      end else begin
        idx = (k < 2) ? {b[3:2], b[7:6]} : {b[1:0], b[5:4]};  // R3
        rp = {p[2], idx[3:2]};
        rc = idx[1:0];
      end
    end else if (rd == 2'd3) begin
      rc = b[7-k] ? 2'd2 : 2'd0;                // R4, R6
      if (!wr) rp = p;
      else     rp = (k < 2) ? {p[2], b[3:2]} : {p[2], b[1:0]};
    end else begin
      rp = {p[2], 2'b00};
      if (wr) rc = {b[7-k], b[3-k]};            // R5
      else    rc = {b[7-k], (k % 2 == 1) ? p[0] : p[1]};  // R7
    end
  endfunction

  function automatic string mode_tag(input logic [1:0] rd, input logic wr);
    if (rd == 2'd1) return "R1";
    if (rd == 2'd0) return wr ? "R3" : "R2";
    if (rd == 2'd3) return wr ? "R6" : "R4";
    return wr ? "R5" : "R7";
  endfunction

  task automatic send(input logic [7:0] b, input logic [2:0] p, input logic [1:0] rd,
                      input logic wr, input logic kg);
    int n;
    n = wr ? 4 : 8;
    in_data = b; in_pal = p; in_rmode = rd; in_wmode = wr; in_kanga = kg; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R10", "ready before byte", int'(in_ready), 1);
    @(posedge clk);
    #1;
    in_data = ~b; in_pal = ~p; in_wmode = ~wr; in_kanga = ~kg; in_rmode = rd ^ 2'd1;
    for (int k = 0; k < n; k++) begin
      logic [2:0] rp, pp;
      logic [1:0] rc, pc;
      logic zero, pz, etr;
      logic [1:0] ecol;
      string tag;
      @(negedge clk);
      ref_raw(b, p, rd, wr, k, rp, rc);
      ref_raw(b, p, rd, wr, k ^ 1, pp, pc);
      zero = (rc == 2'd0);
      pz   = (pc == 2'd0);
      etr  = zero && pz && !kg;                  // R8, R9
      ecol = zero ? 2'd0 : rc;                   // R12
      tag  = zero ? (kg ? "R9 R12" : "R8") : mode_tag(rd, wr);
      chk(out_valid == 1'b1, "R10", "slot valid", int'(out_valid), 1);
      chk(out_color == ecol && out_transp == etr && out_pal == rp, tag, "slot {pal,col,tr}",
          int'({out_pal, out_color, out_transp}), int'({rp, ecol, etr}));
      chk(in_ready == (k == n-1), "R10", "ready during stream", int'(in_ready), int'(k == n-1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11", "ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid after reset", int'(out_valid), 0);

    // Directed: background encoding and pair rule.
    send(8'h00, 3'd5, 2'd0, 1'b0, 1'b1);  // R12: all background, colour 0, opaque
    send(8'h80, 3'd2, 2'd3, 1'b0, 1'b0);  // R8: slot 1 background, slots 2..7 transparent
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "idle after byte", int'(out_valid), 0);

    // Sweep: every byte, every mode pair, both kangaroo settings.
    for (int rd = 0; rd < 4; rd++)
      for (int wr = 0; wr < 2; wr++)
        for (int kg = 0; kg < 2; kg++)
          for (int b = 0; b < 256; b++)
            send(8'(b), 3'((b + 3*rd + wr + kg) & 7), 2'(rd), wr[0], kg[0]);

    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "idle at end", int'(out_valid), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule